// File: doc/BRIEF.md
# CPU Interrupt Entry and Reset Sequencer

This block sits beside the execution core of an 8-bit processor. Whenever the core signals that an instruction has finished, the sequencer decides whether to divert into a non-maskable interrupt, a maskable interrupt, or neither. When it diverts, it stacks the return address and the status byte, raises the interrupt-disable flag, and fetches the new program counter from the matching vector. It also performs the start-up vector fetch that follows a reset. Opcode execution happens elsewhere. The core supplies its live PC, S and P at the boundary and takes the new values back from the sequencer.

Non-maskable requests are remembered in a latch until they are serviced. Maskable requests form a level: a small register of source bits, where each source sets and clears its own bit and the OR of the bits is the request. The mask used for a decision is the interrupt-disable flag the core held when the previous instruction began, not the flag it holds now. One source bit is a one-shot bit that is dropped at every boundary decision. A halt input freezes interrupt service until the next reset.

Top module: `intr_entry_seq`

## Requirements
- R1: When a non-maskable request is latched and maskable sources are also pending at an accepted boundary, the entry taken is the non-maskable one. entryKind codes: 0 none, 1 non-maskable, 2 maskable, 3 reset.
- R2: A maskable entry is taken only if pIn bit 2 (interrupt-disable), as presented at the previous accepted boundary, was 0. The value presented at the current boundary only affects the next decision. After an entry, the flag counts as 1.
- R3: After a jamSet pulse, no boundary produces an entry until rstN is asserted. After the reset, service resumes.
- R4: An entry writes three bytes on consecutive cycles 3, 4 and 5 after the boundary edge, to addresses 0x0100+S, 0x0100+S-1 and 0x0100+S-2. The bytes are, in order, PC[15:8], PC[7:0], and pIn with bit 4 cleared and bit 5 set. spOut then equals S-3.
- R5: In cycles 6 and 7 an entry reads the vector low byte and then the high byte. The addresses are 0xFFFA/0xFFFB for non-maskable and 0xFFFE/0xFFFF for maskable. pcOut is {high,low} and pOut is pIn with bit 2 set.
- R6: An entry keeps busy high for cycles 1 to 7. done is high for exactly cycle 8, with entryKind, pcOut, spOut and pOut valid. There is no bus access in cycles 1, 2 and 8.
- R7: A serviced non-maskable request is cleared, so a later boundary with no new nmiReq pulse produces no entry.
- R8: The maskable level is the OR of the source bits. irqSet/irqClr set and clear individual bits, and a non-one-shot bit stays pending across boundaries until it is cleared.
- R9: Source bit 0 (the one-shot bit) is cleared at every accepted boundary, whether or not an entry was taken.
- R10: After rstN rises, the block reads 0xFFFC in the first cycle and 0xFFFD in the second. In the third cycle done is high with entryKind 3, pcOut {[0xFFFD],[0xFFFC]} and pOut 0x04. While rstN is low, busy is 1 and done and memWe are 0.
- R11: A boundary pulse while busy is high is ignored: the running sequence is unchanged and no further entry follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; starts the start-up vector fetch |
| boundary | input | 1 | Instruction-finished strobe from the core |
| nmiReq | input | 1 | Non-maskable request pulse (latched) |
| irqSet | input | SRC_W | Per-source set strobes for maskable requests |
| irqClr | input | SRC_W | Per-source clear strobes for maskable requests |
| jamSet | input | 1 | Core has halted; blocks service until reset |
| pcIn | input | 16 | Core program counter at the boundary |
| spIn | input | 8 | Core stack pointer at the boundary |
| pIn | input | 8 | Core status byte at the boundary |
| memAddr | output | 16 | Memory address |
| memWe | output | 1 | Memory write enable |
| memRe | output | 1 | Memory read enable |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, sampled at the edge that ends the read cycle |
| busy | output | 1 | Sequence in progress; the core must stall |
| done | output | 1 | One-cycle strobe: new PC/S/P valid |
| entryKind | output | 2 | Kind of the sequence that finished |
| pcOut | output | 16 | New program counter |
| spOut | output | 8 | New stack pointer |
| pOut | output | 8 | New status byte |

## Verification
An entry's stack writes fall in cycles 3 to 5 after the clock edge that samples the boundary. The vector reads fall in cycles 6 and 7, and done, with the new PC, S and P, falls in cycle 8. For reset, the two vector reads land in the first two cycles after release and done lands in the third. The bench raises every stimulus on a falling edge and reads the outputs on the falling edge of each of those numbered cycles, so each result is compared in the one cycle it is due. Decisions that depend on history, such as the delayed mask, the one-shot source and the consumed non-maskable latch, are checked over two or three successive boundaries.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_NMI   = 2'd1,
    KIND_IRQ   = 2'd2,
    KIND_RESET = 2'd3
  } kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  capture;
    logic  pushHi;
    logic  pushLo;
    logic  pushStat;
    logic  readLo;
    logic  readHi;
    kind_e kind;
  } seq_ctrl_t;

  localparam int FLAG_I = 2;
  localparam int FLAG_B = 4;
  localparam int FLAG_U = 5;

  localparam logic [7:0] VEC_NMI_LO = 8'hFA;
  localparam logic [7:0] VEC_RST_LO = 8'hFC;
  localparam logic [7:0] VEC_IRQ_LO = 8'hFE;

endpackage

// File: rtl/irq_seq_src.sv
module irq_seq_src #(
  parameter int SRC_W    = 4,
  parameter int TEMP_BIT = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_W-1:0] irqSet,
  input  logic [SRC_W-1:0] irqClr,
  input  logic             clearTemp,
  output logic             irqLevel
);
  localparam logic [SRC_W-1:0] TEMP_MASK = SRC_W'(1) << TEMP_BIT;

  logic [SRC_W-1:0] srcBits;
  logic [SRC_W-1:0] srcNext;

  always_comb begin
    srcNext = (srcBits & ~irqClr) | irqSet;
    if (clearTemp) srcNext = srcNext & ~TEMP_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcBits <= '0;
    else       srcBits <= srcNext;
  end

  assign irqLevel = |srcBits;

  AST_TEMP_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    clearTemp |=> !srcBits[TEMP_BIT]) else $error("one-shot bit survived a boundary"); // R9

  AST_SRC_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel && irqClr == '0 && !clearTemp) |=> irqLevel) else $error("level dropped"); // R8

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      boundary,
  input  logic      nmiReq,
  input  logic      jamSet,
  input  logic      irqLevel,
  input  logic      pIflag,
  output logic      clearTemp,
  output logic      busy,
  output seq_ctrl_t ctrl
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_INT1, ST_INT2, ST_PCH, ST_PCL, ST_STAT,
    ST_VLO, ST_VHI, ST_RLO, ST_RHI
  } state_e;

  state_e state;
  kind_e  kindQ;
  logic   nmiPend;
  logic   jammed;
  logic   iPrev;
  logic   accept;
  logic   takeNmi;
  logic   takeIrq;

  assign accept  = (state == ST_IDLE) && boundary;
  assign takeNmi = accept && nmiPend && !jammed;
  assign takeIrq = accept && !takeNmi && irqLevel && !iPrev && !jammed;
  assign clearTemp = accept;
  assign busy = (state != ST_IDLE);

  always_comb begin
    ctrl          = '0;
    ctrl.capture  = takeNmi || takeIrq || (state == ST_RLO);
    ctrl.pushHi   = (state == ST_PCH);
    ctrl.pushLo   = (state == ST_PCL);
    ctrl.pushStat = (state == ST_STAT);
    ctrl.readLo   = (state == ST_VLO) || (state == ST_RLO);
    ctrl.readHi   = (state == ST_VHI) || (state == ST_RHI);
    ctrl.kind     = kindQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RLO;
      kindQ   <= KIND_RESET;
      nmiPend <= 1'b0;
      jammed  <= 1'b0;
      iPrev   <= 1'b1;
    end else begin
      nmiPend <= nmiReq || (nmiPend && !takeNmi);
      jammed  <= jammed || jamSet;
      if (accept) iPrev <= (takeNmi || takeIrq) ? 1'b1 : pIflag;
      if (takeNmi)      kindQ <= KIND_NMI;
      else if (takeIrq) kindQ <= KIND_IRQ;
      unique case (state)
        ST_IDLE: if (takeNmi || takeIrq) state <= ST_INT1;
        ST_INT1: state <= ST_INT2;
        ST_INT2: state <= ST_PCH;
        ST_PCH:  state <= ST_PCL;
        ST_PCL:  state <= ST_STAT;
        ST_STAT: state <= ST_VLO;
        ST_VLO:  state <= ST_VHI;
        ST_VHI:  state <= ST_IDLE;
        ST_RLO:  state <= ST_RHI;
        ST_RHI:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (accept && nmiPend && !jammed) |=> (kindQ == KIND_NMI)) else $error("priority"); // R1

  AST_MASK_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (accept && iPrev && !nmiPend) |=> (state == ST_IDLE)) else $error("masked entry"); // R2

  AST_HALT_NO_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (jammed && state == ST_IDLE) |=> (state == ST_IDLE)) else $error("halted entry"); // R3

  AST_NMI_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INT1 && kindQ == KIND_NMI) |-> (!nmiPend || $past(nmiReq))) else $error("nmi kept"); // R7

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && boundary && state != ST_VHI && state != ST_RHI) |=> busy) else $error("busy broken"); // R11

endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter logic [7:0] STACK_PAGE = 8'h01,
  parameter logic [7:0] VEC_PAGE   = 8'hFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  seq_ctrl_t   ctrl,
  input  logic [15:0] pcIn,
  input  logic [7:0]  spIn,
  input  logic [7:0]  pIn,
  input  logic [7:0]  memRdata,
  output logic [15:0] memAddr,
  output logic        memWe,
  output logic        memRe,
  output logic [7:0]  memWdata,
  output logic [15:0] pcOut,
  output logic [7:0]  spOut,
  output logic [7:0]  pOut,
  output logic        done,
  output logic [1:0]  entryKind
);
  localparam logic [7:0] I_MASK = 8'(1) << FLAG_I;
  localparam logic [7:0] B_MASK = 8'(1) << FLAG_B;
  localparam logic [7:0] U_MASK = 8'(1) << FLAG_U;

  logic [15:0] pcSave;
  logic [7:0]  spWork;
  logic [7:0]  pSave;
  logic [7:0]  vecLo;
  logic [7:0]  vecByte;
  logic [15:0] pcQ;
  logic [7:0]  pQ;
  logic        doneQ;
  kind_e       kindOut;
  logic        pushAny;

  assign pushAny = ctrl.pushHi || ctrl.pushLo || ctrl.pushStat;

  always_comb begin
    unique case (ctrl.kind)
      KIND_NMI:   vecByte = VEC_NMI_LO;
      KIND_IRQ:   vecByte = VEC_IRQ_LO;
      default:    vecByte = VEC_RST_LO;
    endcase
  end

  always_comb begin
    memWe    = pushAny;
    memRe    = ctrl.readLo || ctrl.readHi;
    memAddr  = '0;
    memWdata = '0;
    if (pushAny) memAddr = {STACK_PAGE, spWork};
    else if (memRe) memAddr = {VEC_PAGE, vecByte | {7'd0, ctrl.readHi}};
    if (ctrl.pushHi)        memWdata = pcSave[15:8];
    else if (ctrl.pushLo)   memWdata = pcSave[7:0];
    else if (ctrl.pushStat) memWdata = (pSave & ~B_MASK) | U_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcSave  <= '0;
      spWork  <= '0;
      pSave   <= '0;
      vecLo   <= '0;
      pcQ     <= '0;
      pQ      <= '0;
      doneQ   <= 1'b0;
      kindOut <= KIND_NONE;
    end else begin
      doneQ <= ctrl.readHi;
      if (ctrl.capture) begin
        pcSave <= pcIn;
        spWork <= spIn;
        pSave  <= pIn;
      end else if (pushAny) begin
        spWork <= spWork - 8'd1;
      end
      if (ctrl.readLo) vecLo <= memRdata;
      if (ctrl.readHi) begin
        pcQ     <= {memRdata, vecLo};
        pQ      <= (ctrl.kind == KIND_RESET) ? I_MASK : (pSave | I_MASK);
        kindOut <= ctrl.kind;
      end
    end
  end

  assign pcOut     = pcQ;
  assign spOut     = spWork;
  assign pOut      = pQ;
  assign done      = doneQ;
  assign entryKind = kindOut;

  AST_STACK_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr[15:8] == STACK_PAGE)) else $error("push off page"); // R4

  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pushLo |-> (memAddr[7:0] == $past(memAddr[7:0]) - 8'd1)) else $error("sp step"); // R4

  AST_STAT_BITS: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pushStat |-> (memWdata[FLAG_U] && !memWdata[FLAG_B])) else $error("status bits"); // R4

  AST_VEC_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    memRe |-> (memAddr[15:8] == VEC_PAGE)) else $error("vector page"); // R5

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe)) else $error("two accesses"); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done too long"); // R6

  AST_RESET_P: assert property (@(posedge clk) disable iff (!rstN)
    (done && entryKind == 2'd3) |-> (pOut == I_MASK)) else $error("reset status"); // R10

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int         SRC_W      = 4,
  parameter int         TEMP_BIT   = 0,
  parameter logic [7:0] STACK_PAGE = 8'h01,
  parameter logic [7:0] VEC_PAGE   = 8'hFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             boundary,
  input  logic             nmiReq,
  input  logic [SRC_W-1:0] irqSet,
  input  logic [SRC_W-1:0] irqClr,
  input  logic             jamSet,
  input  logic [15:0]      pcIn,
  input  logic [7:0]       spIn,
  input  logic [7:0]       pIn,
  output logic [15:0]      memAddr,
  output logic             memWe,
  output logic             memRe,
  output logic [7:0]       memWdata,
  input  logic [7:0]       memRdata,
  output logic             busy,
  output logic             done,
  output logic [1:0]       entryKind,
  output logic [15:0]      pcOut,
  output logic [7:0]       spOut,
  output logic [7:0]       pOut
);
  seq_ctrl_t ctrl;
  logic      irqLevel;
  logic      clearTemp;

  irq_seq_src #(.SRC_W(SRC_W), .TEMP_BIT(TEMP_BIT)) u_src (
    .clk(clk), .rstN(rstN), .irqSet(irqSet), .irqClr(irqClr),
    .clearTemp(clearTemp), .irqLevel(irqLevel)
  );

  irq_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .boundary(boundary), .nmiReq(nmiReq),
    .jamSet(jamSet), .irqLevel(irqLevel), .pIflag(pIn[FLAG_I]),
    .clearTemp(clearTemp), .busy(busy), .ctrl(ctrl)
  );

  irq_seq_dp #(.STACK_PAGE(STACK_PAGE), .VEC_PAGE(VEC_PAGE)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .pcIn(pcIn), .spIn(spIn), .pIn(pIn),
    .memRdata(memRdata), .memAddr(memAddr), .memWe(memWe), .memRe(memRe),
    .memWdata(memWdata), .pcOut(pcOut), .spOut(spOut), .pOut(pOut),
    .done(done), .entryKind(entryKind)
  );

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy) else $error("done while busy"); // R6

endmodule

// File: tb/intr_entry_seq_tb.sv
`timescale 1ns/1ps
module intr_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        boundary = 1'b0;
  logic        nmiReq = 1'b0;
  logic [3:0]  irqSet = '0;
  logic [3:0]  irqClr = '0;
  logic        jamSet = 1'b0;
  logic [15:0] pcIn = '0;
  logic [7:0]  spIn = '0;
  logic [7:0]  pIn = '0;
  logic [15:0] memAddr;
  logic        memWe, memRe, busy, done;
  logic [7:0]  memWdata, memRdata, spOut, pOut;
  logic [1:0]  entryKind;
  logic [15:0] pcOut;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  intr_entry_seq u_dut (
    .clk(clk), .rstN(rstN), .boundary(boundary), .nmiReq(nmiReq),
    .irqSet(irqSet), .irqClr(irqClr), .jamSet(jamSet), .pcIn(pcIn),
    .spIn(spIn), .pIn(pIn), .memAddr(memAddr), .memWe(memWe), .memRe(memRe),
    .memWdata(memWdata), .memRdata(memRdata), .busy(busy), .done(done),
    .entryKind(entryKind), .pcOut(pcOut), .spOut(spOut), .pOut(pOut)
  );

  // memory model: vectors at the top of the address space
  always_comb begin
    case (memAddr)
      16'hFFFA: memRdata = 8'h34;
      16'hFFFB: memRdata = 8'h12;
      16'hFFFC: memRdata = 8'hCD;
      16'hFFFD: memRdata = 8'hAB;
      16'hFFFE: memRdata = 8'h78;
      16'hFFFF: memRdata = 8'h56;
      default:  memRdata = memAddr[7:0] ^ memAddr[15:8];
    endcase
  end

  // row: {I at first boundary, I at second, nmi pulse, irq set mask[3:0], expected kind[1:0]}
  localparam int NROWS = 8;
  localparam logic [8:0] ROWS [NROWS] = '{
    {1'b0, 1'b0, 1'b0, 4'b0000, 2'd0},
    {1'b0, 1'b1, 1'b0, 4'b0010, 2'd2},  // R2 old flag clear
    {1'b1, 1'b0, 1'b0, 4'b0100, 2'd0},  // R2 old flag set
    {1'b1, 1'b1, 1'b1, 4'b0000, 2'd1},
    {1'b0, 1'b0, 1'b1, 4'b1000, 2'd1},  // R1
    {1'b0, 1'b0, 1'b0, 4'b0001, 2'd2},
    {1'b1, 1'b1, 1'b1, 4'b0010, 2'd1},  // R1
    {1'b0, 1'b0, 1'b0, 4'b1010, 2'd2}   // R8 several sources
  };

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic pulseInputs(input logic nmi, input logic [3:0] setM, input logic [3:0] clrM, input logic jam);
    @(negedge clk);
    nmiReq = nmi; irqSet = setM; irqClr = clrM; jamSet = jam;
    @(negedge clk);
    nmiReq = 0; irqSet = '0; irqClr = '0; jamSet = 0;
  endtask

  task automatic doBoundary(input logic [7:0] p, input logic [15:0] pc, input logic [7:0] sp,
                            input logic [1:0] expKind, input string tag, input bit midPulse);
    logic [7:0] vlo;
    logic [15:0] vpc;
    logic [7:0] stat;
    logic [7:0] spEnd;
    vlo   = (expKind == 2'd1) ? 8'hFA : 8'hFE;
    vpc   = (expKind == 2'd1) ? 16'h1234 : 16'h5678;
    stat  = (p & 8'hEF) | 8'h20;
    spEnd = sp - 8'd3;
    @(negedge clk);
    boundary = 1; pIn = p; pcIn = pc; spIn = sp;
    @(negedge clk);
    boundary = 0;
    for (int k = 1; k <= 8; k++) begin
      if (k > 1) @(negedge clk);
      if (expKind == 2'd0) begin
        chk(tag, "busy stays low", {15'd0, busy}, 16'd0);
        chk(tag, "no done", {15'd0, done}, 16'd0);
        chk(tag, "no write", {15'd0, memWe}, 16'd0);
      end else begin
        chk("R6", "busy window", {15'd0, busy}, (k <= 7) ? 16'd1 : 16'd0);
        case (k)
          3: begin
            chk("R4", "write PCH", {15'd0, memWe}, 16'd1);
            chk("R4", "addr PCH", memAddr, {8'h01, sp});
            chk("R4", "data PCH", {8'd0, memWdata}, {8'd0, pc[15:8]});
          end
          4: begin
            chk("R4", "write PCL", {15'd0, memWe}, 16'd1);
            chk("R4", "addr PCL", memAddr, {8'h01, sp - 8'd1});
            chk("R4", "data PCL", {8'd0, memWdata}, {8'd0, pc[7:0]});
          end
          5: begin
            chk("R4", "write status", {15'd0, memWe}, 16'd1);
            chk("R4", "addr status", memAddr, {8'h01, sp - 8'd2});
            chk("R4", "data status", {8'd0, memWdata}, {8'd0, stat});
          end
          6: begin
            chk("R5", "read low", {15'd0, memRe}, 16'd1);
            chk("R5", "addr low", memAddr, {8'hFF, vlo});
          end
          7: begin
            chk("R5", "read high", {15'd0, memRe}, 16'd1);
            chk("R5", "addr high", memAddr, {8'hFF, vlo | 8'h01});
          end
          8: begin
            chk("R6", "done", {15'd0, done}, 16'd1);
            chk(tag, "kind", {14'd0, entryKind}, {14'd0, expKind});
            chk("R5", "new pc", pcOut, vpc);
            chk("R5", "new p", {8'd0, pOut}, {8'd0, p | 8'h04});
            chk("R4", "new sp", {8'd0, spOut}, {8'd0, spEnd});
            chk("R6", "bus quiet at done", {14'd0, memWe, memRe}, 16'd0);
          end
          default: chk("R6", "bus quiet", {14'd0, memWe, memRe}, 16'd0);
        endcase
      end
      if (midPulse) boundary = (k == 3);
    end
    boundary = 0;
  endtask

  task automatic resetSeq(input string tag);
    @(negedge clk);
    rstN = 0;
    repeat (2) @(negedge clk);
    chk("R10", "busy in reset", {15'd0, busy}, 16'd1);
    chk("R10", "no done in reset", {15'd0, done}, 16'd0);
    chk("R10", "no write in reset", {15'd0, memWe}, 16'd0);
    rstN = 1;
    #0.5;
    chk(tag, "reset read low", {memRe, memAddr[14:0]}, {1'b1, 15'h7FFC});
    @(negedge clk);
    chk(tag, "reset read high", {memRe, memAddr[14:0]}, {1'b1, 15'h7FFD});
    @(negedge clk);
    chk(tag, "reset done", {15'd0, done}, 16'd1);
    chk(tag, "reset kind", {14'd0, entryKind}, 16'd3);
    chk(tag, "reset pc", pcOut, 16'hABCD);
    chk(tag, "reset p", {8'd0, pOut}, 16'h0004);
    chk(tag, "reset busy low", {15'd0, busy}, 16'd0);
    @(negedge clk);
    chk("R6", "done one cycle", {15'd0, done}, 16'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] pa, pb;
    resetSeq("R10");

    // table walk
    for (int i = 0; i < NROWS; i++) begin
      pa = 8'hD1 | (ROWS[i][8] ? 8'h04 : 8'h00);
      pb = 8'hD1 | (ROWS[i][7] ? 8'h04 : 8'h00);
      pulseInputs(1'b0, 4'h0, 4'hF, 1'b0);
      doBoundary(pa, 16'h9000, 8'hF0, 2'd0, "R2", 1'b0);
      pulseInputs(ROWS[i][6], ROWS[i][5:2], 4'h0, 1'b0);
      doBoundary(pb, 16'h8000 + 16'(i * 16'h0111), 8'hFD - 8'(i), ROWS[i][1:0], "R1/R2", 1'b0);
    end
    pulseInputs(1'b0, 4'h0, 4'hF, 1'b0);

    // R7: a serviced NMI does not return on its own
    pulseInputs(1'b1, 4'h0, 4'h0, 1'b0);
    doBoundary(8'h04, 16'h4321, 8'hFF, 2'd1, "R7", 1'b0);
    doBoundary(8'h04, 16'h4322, 8'hFC, 2'd0, "R7", 1'b0);

    // R9: the one-shot bit vanishes at a boundary even when masked
    doBoundary(8'h04, 16'h1000, 8'hF0, 2'd0, "R9", 1'b0);
    pulseInputs(1'b0, 4'b0001, 4'h0, 1'b0);
    doBoundary(8'h00, 16'h1001, 8'hF0, 2'd0, "R9", 1'b0);
    doBoundary(8'h00, 16'h1002, 8'hF0, 2'd0, "R9", 1'b0);

    // R8: an ordinary source survives a masked boundary and is taken later
    doBoundary(8'h04, 16'h2000, 8'hF0, 2'd0, "R8", 1'b0);
    pulseInputs(1'b0, 4'b0100, 4'h0, 1'b0);
    doBoundary(8'h00, 16'h2001, 8'hF0, 2'd0, "R8", 1'b0);
    doBoundary(8'h00, 16'h2002, 8'hE8, 2'd2, "R8", 1'b0);
    pulseInputs(1'b0, 4'h0, 4'b0100, 1'b0);
    doBoundary(8'h00, 16'h2003, 8'hF0, 2'd0, "R8", 1'b0);
    doBoundary(8'h00, 16'h2004, 8'hF0, 2'd0, "R8", 1'b0);

    // R11: a boundary during the sequence is ignored
    pulseInputs(1'b1, 4'h0, 4'h0, 1'b0);
    doBoundary(8'h00, 16'h3333, 8'h80, 2'd1, "R11", 1'b1);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R11", "no extra busy", {15'd0, busy}, 16'd0);
      chk("R11", "no extra done", {15'd0, done}, 16'd0);
    end

    // R3: halted core takes nothing until reset
    doBoundary(8'h00, 16'h5000, 8'hF0, 2'd0, "R3", 1'b0);
    pulseInputs(1'b1, 4'b0010, 4'h0, 1'b1);
    doBoundary(8'h00, 16'h5001, 8'hF0, 2'd0, "R3", 1'b0);
    doBoundary(8'h00, 16'h5002, 8'hF0, 2'd0, "R3", 1'b0);
    resetSeq("R3");
    pulseInputs(1'b1, 4'h0, 4'h0, 1'b0);
    doBoundary(8'h00, 16'h5003, 8'hA0, 2'd1, "R3", 1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule